// File: doc/BRIEF.md
# Segmented Address Translation Unit

This unit turns a virtual reference, given as a segment number and a displacement, into a physical address. A small table of segment descriptors is held in flip-flops. Each descriptor carries a valid flag, a two-bit protection code, a limit (the highest legal displacement) and a base. For each request the unit looks up the descriptor, checks that it is valid, that the displacement is within the limit and that the access type is allowed, and then returns either base plus displacement or a fault code.

Requests are registered. The result appears, with a valid strobe, on the clock edge after the request. Software loads or clears descriptors through a single write port, one descriptor per cycle.

Top module: `segxlate`

## Requirements
- R1: A write with `wr_en` high loads descriptor `wr_seg` (valid, protection, limit, base) at the clock edge. A request in the same cycle is translated with the descriptor contents from before that write.
- R2: With no fault, `rsp_pa` equals (base + displacement) modulo 2^PA_W, where the displacement is zero-extended.
- R3: A displacement strictly greater than the descriptor limit gives fault code 2'b10 (limit violation). A displacement equal to the limit is legal.
- R4: Access codes are 2'b00 read, 2'b01 write, 2'b10 instruction fetch and 2'b11 reserved. Protection codes are 2'b00 any (read, write and fetch allowed), 2'b01 read-only (read only), 2'b10 execute-only (fetch only) and 2'b11 data (read and write, no fetch). A reserved access is never allowed. A disallowed access gives fault code 2'b11.
- R5: Fault codes are 2'b00 none, 2'b01 invalid segment, 2'b10 limit and 2'b11 protection. When several checks fail, invalid segment is reported first, then limit, then protection.
- R6: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. While `rsp_valid` is low, `rsp_fault` and `rsp_pa` are zero.
- R7: Whenever a response carries a nonzero fault code, `rsp_pa` is zero.
- R8: Reset marks every descriptor invalid. A descriptor written with `wr_valid` low is also invalid. Requests to an invalid descriptor give fault code 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_seg | input | SEG_W | Segment number of the request |
| req_disp | input | DISP_W | Displacement of the request |
| req_acc | input | 2 | Access type |
| wr_en | input | 1 | Descriptor write strobe |
| wr_seg | input | SEG_W | Descriptor index to write |
| wr_valid | input | 1 | Valid flag to write |
| wr_prot | input | 2 | Protection code to write |
| wr_limit | input | DISP_W | Limit to write |
| wr_base | input | PA_W | Base to write |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_fault | output | 2 | Fault code |
| rsp_pa | output | PA_W | Physical address, zero on a fault |

## Verification
The hardest case to reach from the ports is a descriptor write and a request to the same segment in one cycle, where the response must still reflect the old descriptor. The bench drives exactly that collision, both when invalidating a live segment and when enabling a dead one. Fault priority needs descriptors on which several checks fail at once. The bench therefore rotates every protection code over every segment, with limits that include 0 and the maximum. In each round it sweeps every displacement and every access type, so that limit and protection faults overlap and base-plus-displacement sums wrap.

// File: rtl/segxlate_pkg.sv
package segxlate_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    PROT_ANY  = 2'b00,
    PROT_RO   = 2'b01,
    PROT_XO   = 2'b10,
    PROT_DATA = 2'b11
  } prot_e;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'b00,
    FLT_INVALID = 2'b01,
    FLT_LIMIT   = 2'b10,
    FLT_PROT    = 2'b11
  } fault_e;

  // Access rule per protection code (R4)
  function automatic logic access_ok(input logic [1:0] prot, input logic [1:0] acc);
    logic ok;
    ok = 1'b0;
    if (acc != ACC_RSVD) begin
      case (prot)
        PROT_ANY:  ok = 1'b1;
        PROT_RO:   ok = (acc == ACC_READ);
        PROT_XO:   ok = (acc == ACC_FETCH);
        default:   ok = (acc != ACC_FETCH);
      endcase
    end
    return ok;
  endfunction

  // Fault priority: invalid, then limit, then protection (R5)
  function automatic fault_e pick_fault(input logic vld, input logic over, input logic ok);
    if (!vld)      return FLT_INVALID;
    else if (over) return FLT_LIMIT;
    else if (!ok)  return FLT_PROT;
    else           return FLT_NONE;
  endfunction

endpackage

// File: rtl/segxlate_table.sv
module segxlate_table #(
  parameter int SEG_W  = 2,
  parameter int DISP_W = 8,
  parameter int PA_W   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEG_W-1:0]  wr_seg,
  input  logic              wr_valid,
  input  logic [1:0]        wr_prot,
  input  logic [DISP_W-1:0] wr_limit,
  input  logic [PA_W-1:0]   wr_base,
  input  logic [SEG_W-1:0]  rd_seg,
  output logic              rd_valid,
  output logic [1:0]        rd_prot,
  output logic [DISP_W-1:0] rd_limit,
  output logic [PA_W-1:0]   rd_base
);
  localparam int NSEG = 1 << SEG_W;

  logic              ent_valid [NSEG];
  logic [1:0]        ent_prot  [NSEG];
  logic [DISP_W-1:0] ent_limit [NSEG];
  logic [PA_W-1:0]   ent_base  [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_ent
    logic sel;
    assign sel = wr_en && (wr_seg == SEG_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_valid[g] <= 1'b0;
        ent_prot[g]  <= '0;
        ent_limit[g] <= '0;
        ent_base[g]  <= '0;
      end else if (sel) begin
        ent_valid[g] <= wr_valid;
        ent_prot[g]  <= wr_prot;
        ent_limit[g] <= wr_limit;
        ent_base[g]  <= wr_base;
      end
    end
  end

  assign rd_valid = ent_valid[rd_seg];
  assign rd_prot  = ent_prot[rd_seg];
  assign rd_limit = ent_limit[rd_seg];
  assign rd_base  = ent_base[rd_seg];
endmodule

// File: rtl/segxlate_check.sv
module segxlate_check
  import segxlate_pkg::*;
#(
  parameter int DISP_W = 8,
  parameter int PA_W   = 10
) (
  input  logic              lk_valid,
  input  logic [1:0]        lk_prot,
  input  logic [DISP_W-1:0] lk_limit,
  input  logic [PA_W-1:0]   lk_base,
  input  logic [DISP_W-1:0] disp,
  input  logic [1:0]        acc,
  output logic              over_limit,
  output logic              acc_allowed,
  output logic [1:0]        fault,
  output logic [PA_W-1:0]   pa
);
  function automatic logic [PA_W-1:0] add_base(input logic [PA_W-1:0] base,
                                               input logic [DISP_W-1:0] d);
    return base + PA_W'(d);
  endfunction

  assign over_limit  = disp > lk_limit;
  assign acc_allowed = access_ok(lk_prot, acc);
  assign fault       = pick_fault(lk_valid, over_limit, acc_allowed);
  assign pa          = (fault == FLT_NONE) ? add_base(lk_base, disp) : '0;
endmodule

// File: rtl/segxlate.sv
module segxlate #(
  parameter int SEG_W  = 2,
  parameter int DISP_W = 8,
  parameter int PA_W   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [DISP_W-1:0] req_disp,
  input  logic [1:0]        req_acc,
  input  logic              wr_en,
  input  logic [SEG_W-1:0]  wr_seg,
  input  logic              wr_valid,
  input  logic [1:0]        wr_prot,
  input  logic [DISP_W-1:0] wr_limit,
  input  logic [PA_W-1:0]   wr_base,
  output logic              rsp_valid,
  output logic [1:0]        rsp_fault,
  output logic [PA_W-1:0]   rsp_pa
);
  logic              lk_valid;
  logic [1:0]        lk_prot;
  logic [DISP_W-1:0] lk_limit;
  logic [PA_W-1:0]   lk_base;
  logic              chk_over;
  logic              chk_allowed;
  logic [1:0]        chk_fault;
  logic [PA_W-1:0]   chk_pa;

  segxlate_table #(.SEG_W(SEG_W), .DISP_W(DISP_W), .PA_W(PA_W)) table_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_seg(wr_seg), .wr_valid(wr_valid), .wr_prot(wr_prot),
    .wr_limit(wr_limit), .wr_base(wr_base),
    .rd_seg(req_seg),
    .rd_valid(lk_valid), .rd_prot(lk_prot), .rd_limit(lk_limit), .rd_base(lk_base)
  );

  segxlate_check #(.DISP_W(DISP_W), .PA_W(PA_W)) check_i (
    .lk_valid(lk_valid), .lk_prot(lk_prot), .lk_limit(lk_limit), .lk_base(lk_base),
    .disp(req_disp), .acc(req_acc),
    .over_limit(chk_over), .acc_allowed(chk_allowed),
    .fault(chk_fault), .pa(chk_pa)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= '0;
      rsp_pa    <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= req_valid ? chk_fault : 2'b00;
      rsp_pa    <= req_valid ? chk_pa : '0;
    end
  end
endmodule

// File: rtl/segxlate_chk.sv
module segxlate_chk #(
  parameter int PA_W = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            wr_en,
  input logic            lk_valid,
  input logic            chk_over,
  input logic            chk_allowed,
  input logic [1:0]      chk_fault,
  input logic            rsp_valid,
  input logic [1:0]      rsp_fault,
  input logic [PA_W-1:0] rsp_pa
);
  logic wr_seen_q;
  always_ff @(posedge clk) begin
    if (!rst_n) wr_seen_q <= 1'b0;
    else if (wr_en) wr_seen_q <= 1'b1;
  end

  p_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_no_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_fault == 2'b00 && rsp_pa == '0));
  p_pa_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'b00) |-> rsp_pa == '0);
  p_reset_invalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !$past(wr_seen_q)) |-> rsp_fault == 2'b01);
  p_prio_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && chk_over) |-> chk_fault == 2'b10);
  p_prot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !chk_over && !chk_allowed) |-> chk_fault == 2'b11);
endmodule

bind segxlate segxlate_chk #(.PA_W(PA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .wr_en(wr_en),
  .lk_valid(lk_valid), .chk_over(chk_over), .chk_allowed(chk_allowed),
  .chk_fault(chk_fault), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
  .rsp_pa(rsp_pa)
);

// File: tb/segxlate_tb_top.sv
`timescale 1ns/1ps
module segxlate_tb_top;
  localparam int SEG_W  = 2;
  localparam int DISP_W = 8;
  localparam int PA_W   = 10;
  localparam int NSEG   = 1 << SEG_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [SEG_W-1:0]  req_seg = '0;
  logic [DISP_W-1:0] req_disp = '0;
  logic [1:0]        req_acc = '0;
  logic              wr_en = 1'b0;
  logic [SEG_W-1:0]  wr_seg = '0;
  logic              wr_valid = 1'b0;
  logic [1:0]        wr_prot = '0;
  logic [DISP_W-1:0] wr_limit = '0;
  logic [PA_W-1:0]   wr_base = '0;
  logic              rsp_valid;
  logic [1:0]        rsp_fault;
  logic [PA_W-1:0]   rsp_pa;

  always #10 clk = ~clk;

  segxlate #(.SEG_W(SEG_W), .DISP_W(DISP_W), .PA_W(PA_W)) dut_i (.*);

  int checks = 0;
  int failures = 0;
  bit done = 0;

  bit m_v    [NSEG];
  int m_prot [NSEG];
  int m_lim  [NSEG];
  int m_base [NSEG];

  bit    pend_v = 0;
  int    pend_f = 0;
  int    pend_pa = 0;
  string pend_tag = "R6";

  // allowed-access masks indexed by protection code, bit = access code (R4)
  function automatic bit perm(int prot, int acc);
    logic [3:0] m;
    case (prot)
      0: m = 4'b0111;
      1: m = 4'b0001;
      2: m = 4'b0100;
      default: m = 4'b0011;
    endcase
    return m[acc];
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_pending();
    if (pend_v) begin
      chk(rsp_valid == 1'b1, "R6 strobe", int'(rsp_valid), 1);
      chk(int'(rsp_fault) == pend_f, pend_tag, int'(rsp_fault), pend_f);
      chk(int'(rsp_pa) == pend_pa, (pend_f != 0) ? "R7 pa" : "R2 pa", int'(rsp_pa), pend_pa);
    end else begin
      chk(rsp_valid == 1'b0 && rsp_fault == 2'b00 && rsp_pa == '0, "R6 idle",
          int'(rsp_valid) + int'(rsp_fault) + int'(rsp_pa), 0);
    end
  endtask

  // One cycle: check the previous response, then drive this cycle's inputs
  task automatic cyc(bit rv, int s, int d, int a,
                     bit we, int ws, bit wv, int wp, int wl, int wb);
    @(negedge clk);
    check_pending();
    req_valid = rv; req_seg = SEG_W'(s); req_disp = DISP_W'(d); req_acc = 2'(a);
    wr_en = we; wr_seg = SEG_W'(ws); wr_valid = wv; wr_prot = 2'(wp);
    wr_limit = DISP_W'(wl); wr_base = PA_W'(wb);
    pend_v = rv;
    if (rv) begin
      if (!m_v[s])             begin pend_f = 1; pend_tag = "R8 invalid"; end
      else if (d > m_lim[s])   begin pend_f = 2; pend_tag = "R3 limit";   end
      else if (!perm(m_prot[s], a)) begin pend_f = 3; pend_tag = "R4 prot"; end
      else                     begin pend_f = 0; pend_tag = "R5 none";    end
      pend_pa = (pend_f == 0) ? (m_base[s] + d) % (1 << PA_W) : 0;
    end
    if (we) begin
      m_v[ws] = wv; m_prot[ws] = wp; m_lim[ws] = wl; m_base[ws] = wb;
    end
  endtask

  task automatic idle(); cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0); endtask

  task automatic do_reset();
    @(negedge clk);
    check_pending();
    rst_n = 1'b0; req_valid = 1'b0; wr_en = 1'b0;
    pend_v = 0;
    for (int i = 0; i < NSEG; i++) m_v[i] = 0;
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b0 && rsp_fault == 2'b00 && rsp_pa == '0, "R6 reset outputs",
        int'(rsp_valid) + int'(rsp_pa), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NSEG; i++) begin m_v[i] = 0; m_prot[i] = 0; m_lim[i] = 0; m_base[i] = 0; end
    do_reset();

    // R8: after reset every segment faults as invalid
    for (int s = 0; s < NSEG; s++)
      for (int a = 0; a < 4; a++) cyc(1, s, s * 37, a, 0, 0, 0, 0, 0, 0);
    idle();

    // R2 R3 R4 R5: rotate protection codes; exhaustive displacement/access sweep
    for (int rnd = 0; rnd < 4; rnd++) begin
      for (int s = 0; s < NSEG; s++) begin
        int lim;
        lim = (s == 0) ? ((rnd % 2 == 0) ? 0 : 255) : (s * 73 + rnd * 41 + 17) % 256;
        cyc(0, 0, 0, 0, 1, s, 1, (s + rnd) % 4, lim, (s * 301 + rnd * 157 + 900) % 1024);
      end
      for (int s = 0; s < NSEG; s++)
        for (int d = 0; d < (1 << DISP_W); d++)
          for (int a = 0; a < 4; a++) cyc(1, s, d, a, 0, 0, 0, 0, 0, 0);
      idle();
    end

    // R1: same-cycle write sees old contents, next request sees new ones
    cyc(0, 0, 0, 0, 1, 1, 1, 0, 200, 1000);
    cyc(1, 1, 50, 0, 1, 1, 0, 0, 0, 0);   // old: legal, pa=(1000+50)%1024
    cyc(1, 1, 50, 0, 0, 0, 0, 0, 0, 0);   // new: R8 cleared entry -> invalid
    cyc(1, 2, 10, 2, 1, 2, 0, 0, 0, 0);
    cyc(1, 2, 10, 2, 1, 2, 1, 2, 10, 5);  // old: invalid; write enables execute-only
    cyc(1, 2, 10, 2, 0, 0, 0, 0, 0, 0);   // new: legal fetch at limit, pa=15
    cyc(1, 2, 11, 1, 0, 0, 0, 0, 0, 0);   // R5: limit before protection
    idle();

    // R8: reset in mid-run clears loaded descriptors
    do_reset();
    for (int s = 0; s < NSEG; s++) cyc(1, s, 0, 0, 0, 0, 0, 0, 0, 0);
    idle();
    idle();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule